// File: doc/BRIEF.md
# Edge/Level Interrupt Pin Service Engine

This block keeps one request bit per interrupt pin (24 by default) and decides, cycle by cycle, when a pin's redirection entry should be turned into an interrupt message. Pin changes arrive as single events (pin number plus asserted or released). Edge pins fire once for each rising request bit. Level pins are held back by a remote-IRR bit that is set when a destination accepts the message and cleared only by a matching level-triggered end-of-interrupt (EOI) broadcast.

The redirection entries (vector, destination, destination mode, trigger mode, delivery mode, mask) come in as inputs from the register file that owns them. The engine produces at most one delivery message per cycle. When several pins are waiting, the lowest-numbered pin goes first. An EOI that frees a level pin whose request is still high sends that pin again at once. A per-pin counter tracks how many times in a row this happens. When the counter reaches a configurable limit, the immediate resend is dropped and a deferral timer is armed instead. When the timer expires, it re-queues every level pin that is still requesting and has a clear remote-IRR. Matching destinations to local interrupt controllers is left to the fabric downstream.

Top module: `pin_service_engine`

## Requirements
- R1: A release event (`line_level`=0) for pin p clears request bit p, and `req_bits[p]` reads 0 from the next cycle.
- R2: An assert event sets request bit p. An edge pin (`ent_trig`=0) is queued for delivery only if its request bit was 0. An assert on an edge pin whose bit is still set is absorbed, and no second message is produced.
- R3: An assert on a level pin (`ent_trig`=1) whose remote-IRR is set records the request but sends nothing.
- R4: A pin whose `ent_mask` bit is 1 never produces a message, and its request bit keeps the value that the events gave it.
- R5: Delivering an edge pin clears its request bit. Delivering a level pin while `dlv_accept`=1 sets its remote-IRR. With `dlv_accept`=0, remote-IRR is left clear.
- R6: An EOI clears remote-IRR on every pin whose vector equals `eoi_vector`, but only when `eoi_level`=1 and `eoi_directed`=0. Any other EOI changes nothing.
- R7: When an EOI clears remote-IRR on an unmasked pin whose request bit is still set, that pin is sent again and its successive-EOI counter goes up by one. A matching EOI that finds the request bit clear zeroes the counter.
- R8: The EOI that brings a pin's counter to `EOI_LIMIT` zeroes the counter and sends nothing. Instead it arms a timer. `DEFER_CYCLES` (default `TICK_RATE`/100) cycles later, every level pin with its request set and remote-IRR clear is re-queued.
- R9: Each message carries the pin's vector, destination, destination mode, trigger mode (0 edge, 1 level) and 3-bit delivery mode, with `out_level`=1 and `out_shorthand`=0.
- R10: Pins that are queued together are sent in ascending pin order, one per cycle.
- R11: Reset clears all request bits, remote-IRR bits, queued services, counters and any armed deferral.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | Pin event strobe |
| line_pin | input | PIN_W | Pin number of the event |
| line_level | input | 1 | 1 asserts the pin, 0 releases it |
| ent_vector | input | NPINS×8 | Vector of each entry |
| ent_dest | input | NPINS×8 | Destination of each entry |
| ent_dest_mode | input | NPINS | Destination mode of each entry |
| ent_trig | input | NPINS | Trigger mode: 0 edge, 1 level |
| ent_dlv | input | NPINS×3 | Delivery mode of each entry |
| ent_mask | input | NPINS | Mask bit of each entry |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | 8 | Vector being acknowledged |
| eoi_level | input | 1 | EOI is for a level-triggered interrupt |
| eoi_directed | input | 1 | Directed-EOI flag of the acknowledging controller |
| dlv_accept | input | 1 | At least one destination accepts the current message |
| out_valid | output | 1 | Delivery message valid this cycle |
| out_pin | output | PIN_W | Pin being delivered |
| out_dest | output | 8 | Destination |
| out_vector | output | 8 | Vector |
| out_dest_mode | output | 1 | Destination mode |
| out_trig | output | 1 | Trigger mode |
| out_dlv | output | 3 | Delivery mode |
| out_level | output | 1 | Level field, always 1 |
| out_shorthand | output | 1 | Shorthand field, always 0 |
| req_bits | output | NPINS | Per-pin request bits |
| remote_irr | output | NPINS | Per-pin remote-IRR bits |

## Verification
The bench drives single edge asserts, which show whether a delivery clears its own request bit. It also sends an assert to an edge pin that is still queued behind other pins, which separates a coalesced request from a fresh one. Level pins are hit with repeat asserts and with EOIs of each kind: edge, directed, non-matching vector, and matching vector with the request still high or already released. This shows that remote-IRR gating, release and immediate resend each happen under their own condition. A run of back-to-back EOIs that first breaks the streak and then reaches the limit separates counter zeroing from throttling, and timer expiry is checked by a later delivery. A single EOI that frees two pins while an edge pin asserts in the same cycle exposes the service order.

// File: rtl/pinsvc_pkg.sv
package pinsvc_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int DLV_W  = 3;

  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;

  // An EOI releases an entry only when it is level, not directed, and the vector matches.
  function automatic logic eoi_releases(logic valid, logic lvl, logic directed,
                                        logic [VEC_W-1:0] ent_vec,
                                        logic [VEC_W-1:0] eoi_vec);
    return valid && lvl && !directed && (ent_vec == eoi_vec);
  endfunction

  // A queued pin may be sent if it still requests; level pins also need remote-IRR clear.
  function automatic logic pin_eligible(logic trig, logic req, logic rirr);
    return req && ((trig == TRIG_EDGE) || !rirr);
  endfunction
endpackage

// File: rtl/pinsvc_pick.sv
module pinsvc_pick #(
  parameter int N  = 24,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  always_comb begin
    any   = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
    if (any) grant[idx] = 1'b1;
  end
endmodule

// File: rtl/pinsvc_eoi_count.sv
module pinsvc_eoi_count #(
  parameter int LIMIT = 10000,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump,
  input  logic zero,
  output logic hit
);
  logic [W-1:0] cnt_q;

  assign hit = bump && (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (hit)      cnt_q <= '0;
    else if (bump)     cnt_q <= cnt_q + 1'b1;
    else if (zero)     cnt_q <= '0;
  end
endmodule

// File: rtl/pinsvc_defer_timer.sv
module pinsvc_defer_timer #(
  parameter int CYCLES = 1000,
  parameter int W      = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic fire
);
  logic         busy_q;
  logic [W-1:0] cnt_q;

  assign fire = busy_q && (cnt_q == W'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (fire) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (arm) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/pin_service_engine.sv
module pin_service_engine
  import pinsvc_pkg::*;
#(
  parameter int NPINS        = 24,
  parameter int EOI_LIMIT    = 10000,
  parameter int TICK_RATE    = 100000,
  parameter int DEFER_CYCLES = (TICK_RATE / 100 > 0) ? TICK_RATE / 100 : 1,
  localparam int PIN_W       = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              line_valid,
  input  logic [PIN_W-1:0]                  line_pin,
  input  logic                              line_level,
  input  logic [NPINS-1:0][VEC_W-1:0]       ent_vector,
  input  logic [NPINS-1:0][DEST_W-1:0]      ent_dest,
  input  logic [NPINS-1:0]                  ent_dest_mode,
  input  logic [NPINS-1:0]                  ent_trig,
  input  logic [NPINS-1:0][DLV_W-1:0]       ent_dlv,
  input  logic [NPINS-1:0]                  ent_mask,
  input  logic                              eoi_valid,
  input  logic [VEC_W-1:0]                  eoi_vector,
  input  logic                              eoi_level,
  input  logic                              eoi_directed,
  input  logic                              dlv_accept,
  output logic                              out_valid,
  output logic [PIN_W-1:0]                  out_pin,
  output logic [DEST_W-1:0]                 out_dest,
  output logic [VEC_W-1:0]                  out_vector,
  output logic                              out_dest_mode,
  output logic                              out_trig,
  output logic [DLV_W-1:0]                  out_dlv,
  output logic                              out_level,
  output logic                              out_shorthand,
  output logic [NPINS-1:0]                  req_bits,
  output logic [NPINS-1:0]                  remote_irr
);
  logic [NPINS-1:0] irr_q, rirr_q, svc_q;
  logic [NPINS-1:0] irr_svc, irr_nxt, rirr_nxt, svc_nxt;
  logic [NPINS-1:0] line_hot, svc_line, svc_eoi, svc_timer;
  logic [NPINS-1:0] eoi_hit, cnt_bump, cnt_zero, cnt_hit;
  logic [NPINS-1:0] edge_clr, rirr_set;
  logic             pick_any;
  logic [PIN_W-1:0] pick_idx;
  logic [NPINS-1:0] pick_grant;
  logic             pick_trig;

  // named internal events
  logic ev_deliver, ev_coalesce, ev_throttle, ev_timer_fire;

  pinsvc_pick #(.N(NPINS), .IW(PIN_W)) u_pick (
    .req(svc_q), .any(pick_any), .idx(pick_idx), .grant(pick_grant)
  );

  assign pick_trig  = ent_trig[pick_idx];
  assign ev_deliver = pick_any && !ent_mask[pick_idx] &&
                      pin_eligible(pick_trig, irr_q[pick_idx], rirr_q[pick_idx]);
  assign edge_clr   = (ev_deliver && pick_trig == TRIG_EDGE) ? pick_grant : '0;
  assign rirr_set   = (ev_deliver && pick_trig == TRIG_LEVEL && dlv_accept) ? pick_grant : '0;

  // pin event decode, applied after this cycle's delivery
  always_comb begin
    for (int i = 0; i < NPINS; i++)
      line_hot[i] = line_valid && (line_pin == PIN_W'(i));
  end

  assign irr_svc = irr_q & ~edge_clr;

  always_comb begin
    logic old_req, tgt_level, tgt_rirr;
    old_req   = |(irr_svc & line_hot);
    tgt_level = |(ent_trig & line_hot);
    tgt_rirr  = |(rirr_q & line_hot);
    ev_coalesce = line_valid && line_level && (|line_hot) &&
                  ((!tgt_level && old_req) || (tgt_level && tgt_rirr));
    svc_line = (line_level && !ev_coalesce) ? line_hot : '0;
    irr_nxt  = line_level ? (irr_svc | line_hot) : (irr_svc & ~line_hot);
  end

  // EOI broadcast
  always_comb begin
    for (int i = 0; i < NPINS; i++)
      eoi_hit[i] = eoi_releases(eoi_valid, eoi_level, eoi_directed, ent_vector[i], eoi_vector);
  end

  assign rirr_nxt = (rirr_q | rirr_set) & ~eoi_hit;
  assign cnt_bump = eoi_hit & ~ent_mask & irr_nxt;
  assign cnt_zero = eoi_hit & ~cnt_bump;

  generate
    for (genvar g = 0; g < NPINS; g++) begin : g_cnt
      pinsvc_eoi_count #(.LIMIT(EOI_LIMIT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .bump(cnt_bump[g]), .zero(cnt_zero[g]), .hit(cnt_hit[g])
      );
    end
  endgenerate

  assign svc_eoi     = cnt_bump & ~cnt_hit;
  assign ev_throttle = |cnt_hit;

  pinsvc_defer_timer #(.CYCLES(DEFER_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(ev_throttle), .fire(ev_timer_fire)
  );

  assign svc_timer = ev_timer_fire ? (ent_trig & irr_nxt & ~rirr_nxt) : '0;
  assign svc_nxt   = (svc_q & ~pick_grant) | svc_line | svc_eoi | svc_timer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0;
      rirr_q <= '0;
      svc_q  <= '0;
    end else begin
      irr_q  <= irr_nxt;
      rirr_q <= rirr_nxt;
      svc_q  <= svc_nxt;
    end
  end

  assign out_valid     = ev_deliver;
  assign out_pin       = pick_idx;
  assign out_dest      = ent_dest[pick_idx];
  assign out_vector    = ent_vector[pick_idx];
  assign out_dest_mode = ent_dest_mode[pick_idx];
  assign out_trig      = pick_trig;
  assign out_dlv       = ent_dlv[pick_idx];
  assign out_level     = 1'b1;
  assign out_shorthand = 1'b0;
  assign req_bits      = irr_q;
  assign remote_irr    = rirr_q;
endmodule

// File: rtl/pinsvc_checks.sv
module pinsvc_checks #(
  parameter int NPINS = 24,
  parameter int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   line_valid,
  input logic [PIN_W-1:0]       line_pin,
  input logic                   line_level,
  input logic [NPINS-1:0][7:0]  ent_vector,
  input logic [NPINS-1:0]       ent_mask,
  input logic                   eoi_valid,
  input logic [7:0]             eoi_vector,
  input logic                   eoi_level,
  input logic                   eoi_directed,
  input logic                   dlv_accept,
  input logic                   ev_deliver,
  input logic [PIN_W-1:0]       out_pin,
  input logic                   out_trig,
  input logic [NPINS-1:0]       req_bits,
  input logic [NPINS-1:0]       remote_irr
);
  logic [NPINS-1:0] rel_mask;
  logic             rel_out_pin;
  logic             line_in_range;

  always_comb begin
    for (int i = 0; i < NPINS; i++)
      rel_mask[i] = eoi_valid && eoi_level && !eoi_directed && (ent_vector[i] == eoi_vector);
  end
  assign rel_out_pin   = rel_mask[out_pin];
  assign line_in_range = int'(line_pin) < NPINS;

  assert_masked_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_deliver |-> !ent_mask[out_pin]);

  assert_level_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_deliver && out_trig) |-> !remote_irr[out_pin]);

  assert_edge_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_deliver && !out_trig && !(line_valid && line_level && line_pin == out_pin))
      |=> !req_bits[$past(out_pin)]);

  assert_accept_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_deliver && out_trig && dlv_accept && !rel_out_pin) |=> remote_irr[$past(out_pin)]);

  assert_eoi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_level && !eoi_directed) |=> ((remote_irr & $past(rel_mask)) == '0));

  assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && !line_level && line_in_range) |=> !req_bits[$past(line_pin)]);

  assert_assert_records_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && line_level && line_in_range) |=> req_bits[$past(line_pin)]);
endmodule

bind pin_service_engine pinsvc_checks #(.NPINS(NPINS), .PIN_W(PIN_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_pin(line_pin),
  .line_level(line_level), .ent_vector(ent_vector), .ent_mask(ent_mask),
  .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
  .eoi_directed(eoi_directed), .dlv_accept(dlv_accept), .ev_deliver(ev_deliver),
  .out_pin(out_pin), .out_trig(out_trig), .req_bits(req_bits), .remote_irr(remote_irr)
);

// File: tb/test_pin_service_engine.sv
module test_pin_service_engine;
  localparam int NPINS = 24;
  localparam int PIN_W = 5;
  localparam int LIMIT = 5;
  localparam int TICKS = 1000;   // deferral = 10 cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;        // 200 MHz

  logic                  line_valid = 0, line_level = 0;
  logic [PIN_W-1:0]      line_pin = '0;
  logic [NPINS-1:0][7:0] ent_vector, ent_dest;
  logic [NPINS-1:0]      ent_dest_mode, ent_trig, ent_mask;
  logic [NPINS-1:0][2:0] ent_dlv;
  logic                  eoi_valid = 0, eoi_level = 0, eoi_directed = 0;
  logic [7:0]            eoi_vector = '0;
  logic                  dlv_accept = 1'b1;
  logic                  out_valid, out_dest_mode, out_trig, out_level, out_shorthand;
  logic [PIN_W-1:0]      out_pin;
  logic [7:0]            out_dest, out_vector;
  logic [2:0]            out_dlv;
  logic [NPINS-1:0]      req_bits, remote_irr;

  pin_service_engine #(.NPINS(NPINS), .EOI_LIMIT(LIMIT), .TICK_RATE(TICKS)) i_pin_service_engine (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_pin(line_pin), .line_level(line_level),
    .ent_vector(ent_vector), .ent_dest(ent_dest), .ent_dest_mode(ent_dest_mode),
    .ent_trig(ent_trig), .ent_dlv(ent_dlv), .ent_mask(ent_mask),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
    .eoi_directed(eoi_directed), .dlv_accept(dlv_accept),
    .out_valid(out_valid), .out_pin(out_pin), .out_dest(out_dest), .out_vector(out_vector),
    .out_dest_mode(out_dest_mode), .out_trig(out_trig), .out_dlv(out_dlv),
    .out_level(out_level), .out_shorthand(out_shorthand),
    .req_bits(req_bits), .remote_irr(remote_irr)
  );

  int ntests = 0;
  int nfail  = 0;
  logic [27:0] exp_q[$];

  // bench's own entry table
  function automatic logic [7:0] tb_vec(int i);
    return (i == 17 || i == 18) ? 8'h60 : 8'(8'h20 + i);
  endfunction
  function automatic logic tb_level(int i);
    return (i >= 16) && (i != 23);
  endfunction

  initial begin
    for (int i = 0; i < NPINS; i++) begin
      ent_vector[i]    = tb_vec(i);
      ent_dest[i]      = 8'(8'h80 | i);
      ent_dest_mode[i] = i[0];
      ent_trig[i]      = tb_level(i);
      ent_dlv[i]       = i[2:0];
      ent_mask[i]      = (i == 3) || (i == 20);
    end
  end

  function automatic logic [27:0] msg_of(int p);
    return {p[4:0], tb_vec(p), 8'(8'h80 | p), p[0], tb_level(p), p[2:0], 2'b10};
  endfunction

  task automatic expect_msg(int p);
    exp_q.push_back(msg_of(p));
  endtask

  task automatic check(logic ok, string tag, int act, int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor (R9 payload, R10 order)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [27:0] act;
      act = {out_pin, out_vector, out_dest, out_dest_mode, out_trig, out_dlv, out_level, out_shorthand};
      if (exp_q.size() == 0) begin
        ntests++; nfail++;
        $display("FAIL R4/R3 unexpected delivery actual=0x%0h expected=none", act);
      end else begin
        logic [27:0] e;
        e = exp_q.pop_front();
        check(act == e, "R9/R10 message", int'(act), int'(e));
      end
    end
  end

  task automatic line(int p, logic lvl);
    @(posedge clk); #1;
    line_valid = 1; line_pin = PIN_W'(p); line_level = lvl;
    @(posedge clk); #1;
    line_valid = 0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic eoi(logic [7:0] v, logic lvl, logic dir);
    @(posedge clk); #1;
    eoi_valid = 1; eoi_vector = v; eoi_level = lvl; eoi_directed = dir;
    @(posedge clk); #1;
    eoi_valid = 0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    ntests++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk); #1;
    // R11 reset state
    check(req_bits == '0 && remote_irr == '0 && !out_valid, "R11 reset state",
          int'(req_bits | remote_irr), 0);

    // R2/R5 edge pin delivers and clears
    expect_msg(0); line(0, 1);
    check(req_bits[0] == 0, "R5 edge clears request", int'(req_bits[0]), 0);

    // R4 masked edge pin, R1 release
    line(3, 1);
    check(req_bits[3] == 1, "R4 masked request kept", int'(req_bits[3]), 1);
    line(3, 0);
    check(req_bits[3] == 0, "R1 release clears", int'(req_bits[3]), 0);

    // R3/R5 level pin 16 (vector 0x30)
    expect_msg(16); line(16, 1);
    check(remote_irr[16] == 1, "R5 accepted level sets remote", int'(remote_irr[16]), 1);
    line(16, 1);
    check(req_bits[16] == 1, "R3 gated request recorded", int'(req_bits[16]), 1);
    // R6 non-releasing EOIs
    eoi(8'h30, 0, 0);
    check(remote_irr[16] == 1, "R6 edge EOI ignored", int'(remote_irr[16]), 1);
    eoi(8'h30, 1, 1);
    check(remote_irr[16] == 1, "R6 directed EOI ignored", int'(remote_irr[16]), 1);
    eoi(8'h31, 1, 0);
    check(remote_irr[16] == 1, "R6 other vector ignored", int'(remote_irr[16]), 1);
    // R7 resend after EOI
    expect_msg(16); eoi(8'h30, 1, 0);
    check(remote_irr[16] == 1, "R7 resent and re-accepted", int'(remote_irr[16]), 1);
    line(16, 0); eoi(8'h30, 1, 0);
    check(remote_irr[16] == 0 && req_bits[16] == 0, "R6 EOI clears remote",
          int'({remote_irr[16], req_bits[16]}), 0);

    // R5 not accepted
    dlv_accept = 0;
    expect_msg(19); line(19, 1);
    check(remote_irr[19] == 0, "R5 refused level keeps remote clear", int'(remote_irr[19]), 0);
    dlv_accept = 1;
    line(19, 0);

    // R4 masked level
    line(20, 1);
    check(req_bits[20] == 1 && remote_irr[20] == 0, "R4 masked level silent",
          int'({req_bits[20], remote_irr[20]}), 2);

    // R10 ordering + R2 coalesce: pins 17/18 share vector 0x60, edge pin 23
    expect_msg(17); line(17, 1);
    expect_msg(18); line(18, 1);
    expect_msg(17); expect_msg(18); expect_msg(23);
    @(posedge clk); #1;
    eoi_valid = 1; eoi_vector = 8'h60; eoi_level = 1; eoi_directed = 0;
    line_valid = 1; line_pin = 5'd23; line_level = 1;
    @(posedge clk); #1;
    eoi_valid = 0;                        // second assert of pin 23 while still queued
    @(posedge clk); #1;
    line_valid = 0;
    repeat (6) @(posedge clk); #1;
    check(req_bits[23] == 0, "R2 coalesced edge single delivery", int'(req_bits[23]), 0);
    check(exp_q.size() == 0, "R10 ascending order drained", exp_q.size(), 0);

    // R7/R8 throttle on pin 21 (vector 0x35)
    expect_msg(21); line(21, 1);
    for (int k = 0; k < 3; k++) begin expect_msg(21); eoi(8'h35, 1, 0); end
    line(21, 0); eoi(8'h35, 1, 0);        // R7 counter zeroed
    check(remote_irr[21] == 0, "R7 no resend without request", int'(remote_irr[21]), 0);
    expect_msg(21); line(21, 1);
    for (int k = 0; k < LIMIT - 1; k++) begin expect_msg(21); eoi(8'h35, 1, 0); end
    eoi(8'h35, 1, 0);                      // reaches limit
    check(remote_irr[21] == 0 && req_bits[21] == 1, "R8 throttled, no resend",
          int'({remote_irr[21], req_bits[21]}), 1);
    expect_msg(21);
    repeat (20) @(posedge clk); #1;
    check(remote_irr[21] == 1, "R8 deferral timer resends", int'(remote_irr[21]), 1);
    expect_msg(21); eoi(8'h35, 1, 0);
    check(remote_irr[21] == 1, "R8 counter restarted after throttle", int'(remote_irr[21]), 1);
    check(exp_q.size() == 0, "R8 all deliveries seen", exp_q.size(), 0);

    // R11 reset mid-run
    @(posedge clk); #1 rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    repeat (2) @(posedge clk); #1;
    check(req_bits == '0 && remote_irr == '0, "R11 reset clears state",
          int'(req_bits | remote_irr), 0);
    repeat (20) @(posedge clk); #1;
    check(exp_q.size() == 0 && !out_valid, "R11 nothing pending after reset", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule